// File: doc/BRIEF.md
# Phase-Frequency Detector with Programmable Antibacklash Delay

This block compares two streams of divider output pulses: one from the reference divider and one from the feedback divider. The feedback divider runs at modulus N = B·P + A. A rising edge on the reference stream sets a flag that drives `up_o`. A rising edge on the feedback stream sets a second flag that drives `dn_o`. Once both flags are set, neither is cleared at once. A shared clear is issued after a delay chosen by a 2-bit width select. Because of this, every comparison leaves a pulse of at least that width on both outputs, even when the two edges coincide. This removes the dead zone of the transfer function near zero phase error. The widths of the two output pulses therefore encode the phase and frequency error for a downstream charge pump.

The block is fully synchronous to a fast sampling clock, and the delay is counted in cycles of that clock. Each divider input passes through a two-flop synchroniser and a rising-edge detector before it can set its flag. An edge can arrive on either input while a clear is pending. Such an edge is held and applied in the cycle after the clear, so it is not lost. The select code that gives the shortest delay is legal but not advised, and a status output reports it.

Top module: `pfd_abl`

## Requirements
- R1: A synchronous reset drives `up_o` and `dn_o` low in the cycle after it is sampled, and clears any partly counted clear delay.
- R2: A rising edge on `ref_pulse_i` sets `up_o`, and a rising edge on `fbk_pulse_i` sets `dn_o`. In each case the output is visible three clock edges after the first edge that samples the new input level.
- R3: Only a 0-to-1 transition sets a flag. An input that stays high does not set its flag again after the flag has been cleared.
- R4: When both outputs are high, they fall together after exactly D cycles of overlap, where D is the selected delay. While the overlap lasts, the two outputs are equal in every cycle.
- R5: The select `abw_sel_i` maps to a delay D of 2 cycles for code 2'b00, 1 cycle for 2'b01, 3 cycles for 2'b10 and 2 cycles for 2'b11.
- R6: `min_width_o` is high exactly when the selected delay is the smallest of the four settings. With the default settings this is code 2'b01. It changes only when `abw_sel_i` changes.
- R7: An edge that is detected while both flags are set, or in the clear cycle itself, is held. It sets its flag in the cycle after the clear, so the output is low for one cycle and then high again.
- R8: A further edge on one input while only that input's flag is set has no effect.
- R9: When one input leads the other by L cycles, the leading output stays high for L + D cycles and the lagging output stays high for D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_pulse_i | input | 1 | Reference divider output, asynchronous |
| fbk_pulse_i | input | 1 | Feedback divider output, asynchronous |
| abw_sel_i | input | 2 | Antibacklash width select |
| up_o | output | 1 | Pump-up request, set by reference edges |
| dn_o | output | 1 | Pump-down request, set by feedback edges |
| min_width_o | output | 1 | High while the shortest, not advised, delay is selected |

## Verification
The checker monitors four properties on every cycle:
- both outputs are low after reset;
- the two outputs fall together at the end of an overlap;
- no overlap lasts longer than the largest configured delay;
- the status bit holds steady while the select holds steady.

The delay each code produces, the lead-plus-delay widths, and the three-edge input latency need exact cycle counts, so only the bench's scenarios can show them. The same holds for held edges during a clear, ignored repeat edges and level-held inputs. The bench drives coincident, reference-leading, feedback-leading and repeat-edge patterns, and compares each cycle against expected waveforms.

// File: rtl/pfd_abl_pkg.sv
package pfd_abl_pkg;

   // Two-bit antibacklash select codes
   typedef enum logic [1:0] {
      ABW_C00 = 2'b00,
      ABW_C01 = 2'b01,
      ABW_C10 = 2'b10,
      ABW_C11 = 2'b11
   } abw_code_t;

   // Delay in sampling-clock cycles for a given select code
   function automatic int pick_delay(input logic [1:0] code,
                                     input int d00, input int d01,
                                     input int d10, input int d11);
      case (code)
         ABW_C00: pick_delay = d00;
         ABW_C01: pick_delay = d01;
         ABW_C10: pick_delay = d10;
         default: pick_delay = d11;
      endcase
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic int min4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b < m) m = b;
      if (c < m) m = c;
      if (d < m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic din_i,
   output logic rise_o
);
   // Synchroniser stages plus one history flop for the edge detector
   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) pipe_q <= '0;
      else       pipe_q <= {pipe_q[STAGES-1:0], din_i};
   end

   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/pfd_flag_ch.sv
module pfd_flag_ch (
   input  logic clk_i,
   input  logic rst_i,
   input  logic rise_i,   // synchronised rising edge of this channel
   input  logic pend_i,   // both flags set: clear is pending
   input  logic clr_i,    // shared clear fires this cycle
   output logic flag_o
);
   logic flag_q;
   logic hold_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         flag_q <= 1'b0;
         hold_q <= 1'b0;
      end else if (clr_i) begin
         // Clear wins; an edge arriving now is deferred
         flag_q <= 1'b0;
         hold_q <= hold_q | rise_i;
      end else if (pend_i) begin
         // Flag already set; remember any new edge
         hold_q <= hold_q | rise_i;
      end else begin
         // Idle or single flag: apply a held or fresh edge
         if (hold_q | rise_i) flag_q <= 1'b1;
         hold_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/pfd_clr_timer.sv
module pfd_clr_timer #(
   parameter int CW = 2
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          both_i,
   input  logic [CW-1:0] dly_i,
   output logic          clr_o
);
   logic [CW-1:0] cnt_q;

   // Fires in the D-th cycle of overlap so flags drop after D cycles
   assign clr_o = both_i & (cnt_q == (dly_i - CW'(1)));

   always_ff @(posedge clk_i) begin
      if (rst_i)                cnt_q <= '0;
      else if (!both_i || clr_o) cnt_q <= '0;
      else                      cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/pfd_abl.sv
module pfd_abl #(
   parameter int SYNC_STAGES = 2,
   parameter int DLY_00      = 2,
   parameter int DLY_01      = 1,
   parameter int DLY_10      = 3,
   parameter int DLY_11      = 2
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       ref_pulse_i,
   input  logic       fbk_pulse_i,
   input  logic [1:0] abw_sel_i,
   output logic       up_o,
   output logic       dn_o,
   output logic       min_width_o
);
   import pfd_abl_pkg::*;

   localparam int NCH     = 2;
   localparam int MAX_DLY = max4(DLY_00, DLY_01, DLY_10, DLY_11);
   localparam int MIN_DLY = min4(DLY_00, DLY_01, DLY_10, DLY_11);
   localparam int CW      = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY + 1);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pfd_abl: SYNC_STAGES must be at least 2");
   end
   if (MIN_DLY < 1) begin : g_bad_dly
      $error("pfd_abl: every antibacklash delay must be at least 1 cycle");
   end

   logic [NCH-1:0] pin_w;
   logic [NCH-1:0] rise_w;
   logic [NCH-1:0] flag_w;
   logic           both_w;
   logic           clr_w;
   logic [CW-1:0]  dly_w;

   assign pin_w  = {fbk_pulse_i, ref_pulse_i};
   assign both_w = &flag_w;
   assign dly_w  = CW'(pick_delay(abw_sel_i, DLY_00, DLY_01, DLY_10, DLY_11));

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .din_i  (pin_w[g]),
         .rise_o (rise_w[g])
      );
      pfd_flag_ch u_flag (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .rise_i (rise_w[g]),
         .pend_i (both_w),
         .clr_i  (clr_w),
         .flag_o (flag_w[g])
      );
   end

   pfd_clr_timer #(.CW(CW)) u_timer (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .both_i (both_w),
      .dly_i  (dly_w),
      .clr_o  (clr_w)
   );

   assign up_o        = flag_w[0];
   assign dn_o        = flag_w[1];
   assign min_width_o = (dly_w == CW'(MIN_DLY));
endmodule

// File: rtl/pfd_abl_chk.sv
module pfd_abl_chk #(
   parameter int DLY_00 = 2,
   parameter int DLY_01 = 1,
   parameter int DLY_10 = 3,
   parameter int DLY_11 = 2
) (
   input logic       clk_i,
   input logic       rst_i,
   input logic       up_o,
   input logic       dn_o,
   input logic [1:0] abw_sel_i,
   input logic       min_width_o
);
   localparam int MAX_DLY = pfd_abl_pkg::max4(DLY_00, DLY_01, DLY_10, DLY_11);
   localparam int OW      = $clog2(MAX_DLY + 2);

   // Overlap length counter, saturating
   logic [OW-1:0] ovl_q;
   always_ff @(posedge clk_i) begin
      if (rst_i)                   ovl_q <= '0;
      else if (!(up_o && dn_o))    ovl_q <= '0;
      else if (ovl_q != '1)        ovl_q <= ovl_q + OW'(1);
   end

   assert_reset_low_R1: assert property (@(posedge clk_i)
      rst_i |=> (!up_o && !dn_o));

   assert_fall_together_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (up_o && dn_o) |=> (up_o == dn_o));

   assert_overlap_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (up_o && dn_o) |-> (ovl_q < OW'(MAX_DLY)));

   assert_status_steady_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      $stable(abw_sel_i) |-> $stable(min_width_o));
endmodule

bind pfd_abl pfd_abl_chk #(
   .DLY_00(DLY_00), .DLY_01(DLY_01), .DLY_10(DLY_10), .DLY_11(DLY_11)
) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .up_o        (up_o),
   .dn_o        (dn_o),
   .abw_sel_i   (abw_sel_i),
   .min_width_o (min_width_o)
);

// File: tb/pfd_abl_tb.sv
module pfd_abl_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ref_p = 1'b0;
   logic       fbk_p = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       up, dn, minw;

   int total = 0;
   int bad   = 0;

   typedef struct {
      logic  up;
      logic  dn;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;   // 125 MHz

   pfd_abl u_dut (
      .clk_i(clk), .rst_i(rst), .ref_pulse_i(ref_p), .fbk_pulse_i(fbk_p),
      .abw_sel_i(sel), .up_o(up), .dn_o(dn), .min_width_o(minw)
   );

   function automatic logic in_rng(int n, int lo, int hi);
      return (n >= lo) && (n <= hi);
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Monitor: compares the design against expected items after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " up"}, up, e.up);
            chk({e.tag, " dn"}, dn, e.dn);
         end
      end
   end

   // Driver: ref pulses at r1/r2 (width rw), fbk pulses at f1/f2 (width 2).
   // Expected ranges are in the observation index n = step + 1.
   task automatic scen(string tag, logic [1:0] code, int len,
                       int r1, int r2, int rw, int f1, int f2,
                       int u1l, int u1h, int u2l, int u2h,
                       int d1l, int d1h, int d2l, int d2h);
      for (int i = 0; i < len; i++) begin
         exp_t e;
         @(negedge clk);
         sel   = code;
         ref_p = in_rng(i, r1, r1 + rw - 1) | ((r2 >= 0) & in_rng(i, r2, r2 + rw - 1));
         fbk_p = in_rng(i, f1, f1 + 1) | ((f2 >= 0) & in_rng(i, f2, f2 + 1));
         e.up  = in_rng(i + 1, u1l, u1h) | in_rng(i + 1, u2l, u2h);
         e.dn  = in_rng(i + 1, d1l, d1h) | in_rng(i + 1, d2l, d2h);
         e.tag = tag;
         sb_q.push_back(e);
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset up", up, 1'b0);
      chk("R1 reset dn", dn, 1'b0);
      rst = 1'b0;

      // R6: status bit per code
      sel = 2'b00; #1 chk("R6 code00", minw, 1'b0);
      sel = 2'b01; #1 chk("R6 code01", minw, 1'b1);
      sel = 2'b10; #1 chk("R6 code10", minw, 1'b0);
      sel = 2'b11; #1 chk("R6 code11", minw, 1'b0);

      // R2, R9: ref leads by 4, D=2 -> up 3..8, dn 7..8
      scen("R2_R9 ref lead", 2'b00, 14, 0, -1, 2, 4, -1, 3, 8, -1, -2, 7, 8, -1, -2);
      // R2, R9: fbk leads by 3, D=3 -> dn 3..8, up 6..8
      scen("R2_R9 fbk lead", 2'b10, 14, 3, -1, 2, 0, -1, 6, 8, -1, -2, 3, 8, -1, -2);
      // R4, R5: coincident, width equals D per code
      scen("R4_R5 code01", 2'b01, 8, 0, -1, 2, 0, -1, 3, 3, -1, -2, 3, 3, -1, -2);
      scen("R4_R5 code00", 2'b00, 8, 0, -1, 2, 0, -1, 3, 4, -1, -2, 3, 4, -1, -2);
      scen("R4_R5 code11", 2'b11, 8, 0, -1, 2, 0, -1, 3, 4, -1, -2, 3, 4, -1, -2);
      scen("R4_R5 code10", 2'b10, 9, 0, -1, 2, 0, -1, 3, 5, -1, -2, 3, 5, -1, -2);
      // R8: second ref edge while only up is set is ignored
      scen("R8 repeat edge", 2'b00, 22, 0, 4, 2, 12, -1, 3, 16, -1, -2, 15, 16, -1, -2);
      // R3: ref held high, only one up pulse
      scen("R3 level held", 2'b00, 26, 0, -1, 20, 5, -1, 3, 9, -1, -2, 8, 9, -1, -2);
      // R7: ref edge lands on the clear cycle, applied one cycle later
      scen("R7 held edge", 2'b10, 20, 0, 3, 2, 0, 10, 3, 5, 7, 15, 3, 5, 13, 15);

      // R1: reset in the middle of a pending clear
      wait (sb_q.size() == 0);
      @(negedge clk);
      sel = 2'b10; ref_p = 1'b1; fbk_p = 1'b1;
      repeat (2) @(negedge clk);
      ref_p = 1'b0; fbk_p = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 overlap before reset up", up, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 after reset up", up, 1'b0);
      chk("R1 after reset dn", dn, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      // Full width after reset shows the delay count was cleared
      scen("R1 count cleared", 2'b10, 9, 0, -1, 2, 0, -1, 3, 5, -1, -2, 3, 5, -1, -2);
      wait (sb_q.size() == 0);
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule